// File: doc/BRIEF.md
# Base-and-Limit Segment Translator

This block maps a 16-bit virtual address onto a 16-bit physical address. It uses a table of four segments, and each segment has its own base and limit. The two most significant address bits pick the segment. The remaining fourteen bits are an offset into it. The offset is compared with the segment's limit and then added to the segment's base. An access outside the segment, or one whose sum runs past the top of the physical space, is reported as a fault, and no address is given for it.

The lookup is purely combinational. A request presented with its valid bit gets its answer in the same cycle. Software loads the table through a write port that only acts while the kernel-mode input is high. A write tried from user mode leaves the table untouched and raises a one-cycle denial flag.

Two address spaces can share memory only a whole segment at a time. To do so, both are given entries with the same base and limit. The reset contents of the table are a small example layout: code, data, shared and stack segments.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset the table holds segment 0 base 0x4000 limit 0x0800, segment 1 base 0x4800 limit 0x1400, segment 2 base 0xF000 limit 0x1000, and segment 3 base 0x0000 limit 0x3000.
- R2: With `va_valid` high, `va[15:14]` selects the segment and `va[13:0]` is the offset. When no fault occurs, `pa_valid` is high and `pa` equals base plus offset in the same cycle.
- R3: An offset greater than or equal to the selected limit gives `pa_fault` high, `pa_valid` low and `pa` = 0.
- R4: A segment whose limit is 0 faults on every offset.
- R5: If base plus offset carries past bit 15, the access faults (`pa_fault` high, `pa_valid` low, `pa` = 0), even when the offset is below the limit.
- R6: With `kern_mode` and `wr_en` high at a rising edge, entry `wr_sel` takes `wr_base` and `wr_limit`. Translations use the new values from the next cycle on.
- R7: With `wr_en` high and `kern_mode` low at a rising edge, the table keeps its contents, and `wr_denied` is high for the following cycle. After a kernel-mode write, or when no write is made, `wr_denied` stays low.
- R8: With `va_valid` low, `pa_valid`, `pa_fault` and `pa` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| kern_mode | input | 1 | High when the requester runs in kernel mode |
| wr_en | input | 1 | Table write request |
| wr_sel | input | 2 | Entry to write |
| wr_base | input | 16 | Base value to load |
| wr_limit | input | 16 | Limit value to load |
| wr_denied | output | 1 | Pulses high the cycle after a user-mode write attempt |
| va_valid | input | 1 | Virtual address valid |
| va | input | 16 | Virtual address |
| pa_valid | output | 1 | Physical address valid |
| pa_fault | output | 1 | Access error for the current request |
| pa | output | 16 | Physical address, 0 unless `pa_valid` |

## Verification
The hardest case to reach is the carry fault. With the reset table, no in-range offset can carry, because the shared segment's limit stops exactly at 0xFFFF. The stimulus therefore first loads new entries in kernel mode: a high base with a limit of 0x4000 and a zero limit. It then sweeps the whole offset range of every segment in strides, and adds the exact boundary offsets. This covers the carry edge, the limit edge and the dead segment, together with reads that follow right after a write.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  // Reset contents of the segment table, indexed by segment number.
  function automatic logic [31:0] seg_rst_base(input int idx);
    case (idx)
      0:       return 32'h0000_4000;
      1:       return 32'h0000_4800;
      2:       return 32'h0000_F000;
      default: return 32'h0000_0000;
    endcase
  endfunction

  function automatic logic [31:0] seg_rst_limit(input int idx);
    case (idx)
      0:       return 32'h0000_0800;
      1:       return 32'h0000_1400;
      2:       return 32'h0000_1000;
      3:       return 32'h0000_3000;
      default: return 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kern_mode,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_limit,
  input  logic [SEG_W-1:0]  rd_sel,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] rd_limit,
  output logic              wr_denied
);
  localparam int NSEG = 1 << SEG_W;

  logic [NSEG-1:0][ADDR_W-1:0] base_q, limit_q;
  logic [NSEG-1:0]             ld_en;
  logic                        deny_d, deny_q;

  always_comb begin
    ld_en = '0;
    if (wr_en && kern_mode) ld_en[wr_sel] = 1'b1;
    deny_d = wr_en && !kern_mode;
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_ent
    localparam logic [31:0] RB = seg_rst_base(i);
    localparam logic [31:0] RL = seg_rst_limit(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[i]  <= RB[ADDR_W-1:0];
        limit_q[i] <= RL[ADDR_W-1:0];
      end else if (ld_en[i]) begin
        base_q[i]  <= wr_base;
        limit_q[i] <= wr_limit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) deny_q <= 1'b0;
    else        deny_q <= deny_d;
  end

  assign rd_base   = base_q[rd_sel];
  assign rd_limit  = limit_q[rd_sel];
  assign wr_denied = deny_q;

  // R6
  kern_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kern_mode) |=> (base_q[$past(wr_sel)] == $past(wr_base)) &&
                             (limit_q[$past(wr_sel)] == $past(wr_limit)));
  // R7
  user_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !kern_mode) |=> $stable(base_q) && $stable(limit_q) && wr_denied);
endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic [ADDR_W-SEG_W-1:0] offset,
  input  logic [ADDR_W-1:0]       base,
  input  logic [ADDR_W-1:0]       limit,
  output logic [ADDR_W-1:0]       sum,
  output logic                    flt
);
  localparam int OFF_W = ADDR_W - SEG_W;

  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W:0]   wide_sum;
  logic              over_lim, carry;

  always_comb begin
    off_ext  = {{SEG_W{1'b0}}, offset};
    wide_sum = {1'b0, base} + {1'b0, off_ext};
    over_lim = (off_ext >= limit);
    carry    = wide_sum[ADDR_W];
    sum      = wide_sum[ADDR_W-1:0];
    flt      = over_lim || carry;
  end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top #(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kern_mode,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [ADDR_W-1:0] wr_limit,
  output logic              wr_denied,
  input  logic              va_valid,
  input  logic [ADDR_W-1:0] va,
  output logic              pa_valid,
  output logic              pa_fault,
  output logic [ADDR_W-1:0] pa
);
  localparam int OFF_W = ADDR_W - SEG_W;

  logic [1:0]        rs_q;
  logic              rst_sync_n;
  logic [SEG_W-1:0]  seg;
  logic [OFF_W-1:0]  off;
  logic [ADDR_W-1:0] cur_base, cur_limit, sum;
  logic              flt;

  // Reset asserts at once, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign seg = va[ADDR_W-1 -: SEG_W];
  assign off = va[OFF_W-1:0];

  seg_table #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .kern_mode (kern_mode),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_base   (wr_base),
    .wr_limit  (wr_limit),
    .rd_sel    (seg),
    .rd_base   (cur_base),
    .rd_limit  (cur_limit),
    .wr_denied (wr_denied)
  );

  seg_check #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_chk (
    .offset (off),
    .base   (cur_base),
    .limit  (cur_limit),
    .sum    (sum),
    .flt    (flt)
  );

  always_comb begin
    pa_valid = va_valid && !flt;
    pa_fault = va_valid && flt;
    pa       = pa_valid ? sum : '0;
  end

  // R3
  limit_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pa_valid |-> ({{SEG_W{1'b0}}, off} < cur_limit));
  // R3
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pa_fault |-> (!pa_valid && pa == '0));
  // R5
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pa_valid |-> (pa >= cur_base));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !va_valid |-> (!pa_valid && !pa_fault && pa == '0));
endmodule

// File: tb/sim_seg_xlate_top.sv
module sim_seg_xlate_top;
  logic        clk = 1'b0;
  logic        rst_n, kern_mode, wr_en, va_valid;
  logic [1:0]  wr_sel;
  logic [15:0] wr_base, wr_limit, va;
  logic        wr_denied, pa_valid, pa_fault;
  logic [15:0] pa;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mb [4];
  logic [15:0] ml [4];

  always #5 clk = ~clk;

  seg_xlate_top u0 (
    .clk(clk), .rst_n(rst_n), .kern_mode(kern_mode), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_base(wr_base), .wr_limit(wr_limit),
    .wr_denied(wr_denied), .va_valid(va_valid), .va(va),
    .pa_valid(pa_valid), .pa_fault(pa_fault), .pa(pa)
  );

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk1(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one request at the falling edge and sample 2 ns later.
  task automatic xlate(input logic [15:0] a, input string tag_ok);
    logic [1:0]  s;
    logic [16:0] w;
    logic        f;
    string       tag;
    @(negedge clk);
    va_valid = 1'b1;
    va = a;
    s = a[15:14];
    w = {1'b0, mb[s]} + {3'b000, a[13:0]};
    tag = tag_ok;
    f = 1'b0;
    if (ml[s] == 16'h0) begin f = 1'b1; tag = "R4"; end
    else if ({2'b00, a[13:0]} >= ml[s]) begin f = 1'b1; tag = "R3"; end
    else if (w[16]) begin f = 1'b1; tag = "R5"; end
    #2;
    chk1(tag, {15'd0, pa_valid, pa_fault, pa}, {15'd0, !f, f, f ? 16'h0 : w[15:0]});
  endtask

  task automatic tbl_write(input logic km, input logic [1:0] s,
                           input logic [15:0] b, input logic [15:0] l);
    @(negedge clk);
    va_valid = 1'b0;
    kern_mode = km; wr_en = 1'b1; wr_sel = s; wr_base = b; wr_limit = l;
    @(negedge clk);
    wr_en = 1'b0; kern_mode = 1'b0;
    if (km) begin mb[s] = b; ml[s] = l; end
    #2;
    chk1("R7", {31'd0, wr_denied}, {31'd0, !km});
  endtask

  task automatic sweep;
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 16384; o += 13)
        xlate({s[1:0], o[13:0]}, "R2");
      for (int d = -1; d <= 0; d++) begin
        int e = int'(ml[s]) + d;
        if (e >= 0 && e < 16384) xlate({s[1:0], e[13:0]}, "R2");
      end
      xlate({s[1:0], 14'h3FFF}, "R2");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    mb[0] = 16'h4000; ml[0] = 16'h0800;
    mb[1] = 16'h4800; ml[1] = 16'h1400;
    mb[2] = 16'hF000; ml[2] = 16'h1000;
    mb[3] = 16'h0000; ml[3] = 16'h3000;
    rst_n = 1'b0; kern_mode = 1'b0; wr_en = 1'b0; wr_sel = '0;
    wr_base = '0; wr_limit = '0; va_valid = 1'b0; va = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    // R8 and reset state of the denial flag
    chk1("R8", {15'd0, pa_valid, pa_fault, pa}, 32'd0);
    chk1("R7", {31'd0, wr_denied}, 32'd0);

    // R1: offset 0 and last legal offset of each reset entry
    for (int s = 0; s < 4; s++) begin
      xlate({s[1:0], 14'h0}, "R1");
      xlate({s[1:0], 14'(ml[s] - 16'd1)}, "R1");
    end
    sweep();

    // R7: user-mode write has no effect
    tbl_write(1'b0, 2'd0, 16'h1234, 16'h3FFF);
    xlate(16'h0000, "R7");
    xlate(16'h0800, "R7");

    // R6, R4, R5: kernel loads
    tbl_write(1'b1, 2'd1, 16'h2000, 16'h0000);
    xlate(16'h4000, "R6");
    tbl_write(1'b1, 2'd2, 16'hF000, 16'h4000);
    xlate(16'h8FFF, "R6");
    xlate(16'h9000, "R5");
    tbl_write(1'b1, 2'd3, 16'hC001, 16'h4000);
    xlate(16'hFFFE, "R6");
    xlate(16'hFFFF, "R5");
    tbl_write(1'b1, 2'd0, 16'h0100, 16'h0200);
    sweep();

    // R8: idle requests
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      va_valid = 1'b0;
      va = 16'(k * 16'h2345);
      #2;
      chk1("R8", {15'd0, pa_valid, pa_fault, pa}, 32'd0);
    end
    report();
  end
endmodule